// File: doc/BRIEF.md
# Stereo Serial Audio Master Port

This block is the serial audio port between a pair of stereo converters and the processing core. It is the clock master on the bus. From the fabric clock it derives the bit clock and the channel-select (word-select) line. One shared timing generator paces both the capture path and the playback path, so the two directions always run on the same frames. Each frame has two 32-bit slots, left and then right. Each slot carries a 24-bit sample, MSB first, and the sample begins one bit clock after the channel-select edge.

On the capture side, the block shifts in the converter's serial data and delivers each finished frame to the core as a parallel left/right pair with a one-cycle valid pulse. On the playback side, the core loads a parallel pair with a strobe. The pair waits in a holding register and goes on the wire in the next frame. If no new pair arrives, the last one is sent again. With the default settings (a 48 kHz frame and 64 bit clocks per frame) the bit clock is 3.072 MHz. The bit-clock half period, in fabric cycles, is a parameter.

Top module: `i2s_master_if`

## Requirements
- R1: `bclk_o` stays high for `BCLK_HALF` fabric cycles and low for `BCLK_HALF` fabric cycles. A frame lasts 64 bit-clock periods, which is `128*BCLK_HALF` fabric cycles between successive rising edges of `ws_o`.
- R2: `ws_o` is 0 for the left slot and 1 for the right slot. It changes only when `bclk_o` falls, and it changes one bit before the first bit of the slot it selects, so each level of `ws_o` covers exactly 32 rising edges of `bclk_o`.
- R3: `sdout_o` changes only when `bclk_o` falls. Each slot sends the 24 sample bits MSB first, and the remaining 8 bit positions of the slot are 0.
- R4: `sdin_i` is sampled on the rising edge of `bclk_o`. The first 24 bits of each slot form the sample MSB first, and the last 8 bits of the slot have no effect on `rx_left_o` or `rx_right_o`.
- R5: `rx_valid_o` is a one-cycle pulse once per frame. It is raised right after the rising `bclk_o` edge of the last bit of the right slot, while `ws_o` is 0 and `bclk_o` is 1. It carries that frame's pair on `rx_left_o`/`rx_right_o`. No pulse comes before the first full frame after reset.
- R6: A pair loaded with `tx_load_i` during frame N is sent in frame N+1. When several loads fall in one frame, the last one is sent.
- R7: A frame in which nothing was loaded is followed by a frame that repeats the previous pair.
- R8: A load taken in the same fabric cycle as the falling `bclk_o` edge that starts a frame counts as a load during that new frame, so it goes out one frame later.
- R9: During reset `bclk_o`, `ws_o`, `sdout_o` and `rx_valid_o` are 0 and the received pair is zero. The first frame sent after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_o | output | 1 | Bit clock to both converters |
| ws_o | output | 1 | Channel select, 0 = left, 1 = right |
| sdin_i | input | 1 | Serial data from the ADC |
| sdout_o | output | 1 | Serial data to the DAC |
| rx_left_o | output | 24 | Captured left sample |
| rx_right_o | output | 24 | Captured right sample |
| rx_valid_o | output | 1 | One-cycle pulse: a captured pair is ready |
| tx_left_i | input | 24 | Left sample to send |
| tx_right_i | input | 24 | Right sample to send |
| tx_load_i | input | 1 | Strobe that takes `tx_left_i`/`tx_right_i` |

## Verification
The collision that matters is a core load strobe landing in the very fabric cycle where the timing generator starts a new frame and hands the holding register to the shifter. The bench times the strobe from the falling edge of `ws_o` so that it is sampled exactly at that frame-start edge. It then decodes the serial output and expects the old pair in the frame just started and the new pair only in the frame after. Randomly timed single and double loads, with and without idle frames, are judged the same way against an expected per-frame pair computed from the load history.

// File: rtl/i2s_pkg.sv
package i2s_pkg;
  // Single-cycle events from the timing generator, one cycle before the bclk edge.
  typedef struct packed {
    logic rise;         // bclk goes high at the next edge
    logic fall;         // bclk goes low at the next edge
    logic frame_start;  // fall that starts bit position 0
    logic frame_end;    // rise of the last bit position
  } i2s_tick_t;
endpackage

// File: rtl/i2s_timing_gen.sv
module i2s_timing_gen
  import i2s_pkg::*;
#(
  parameter int SLOT_W    = 32,
  parameter int BCLK_HALF = 2,
  parameter int POS_W     = $clog2(2 * SLOT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             bclk_o,
  output logic             ws_o,
  output i2s_tick_t        tick_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int CNT_W = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BCLK_HALF - 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(2 * SLOT_W - 1);
  localparam logic [POS_W-1:0] WS_UP    = POS_W'(SLOT_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bclk_q, ws_q, wrap;
  logic [POS_W-1:0] pos_q, pos_nxt;
  logic             ws_nxt;

  assign wrap    = (cnt_q == CNT_LAST);
  assign pos_nxt = pos_q + 1'b1;
  // ws leads the slot by one bit
  assign ws_nxt  = (pos_nxt >= WS_UP) && (pos_nxt != LAST_POS);

  always_comb begin
    tick_o.rise        = wrap && !bclk_q;
    tick_o.fall        = wrap && bclk_q;
    tick_o.frame_start = tick_o.fall && (pos_q == LAST_POS);
    tick_o.frame_end   = tick_o.rise && (pos_q == LAST_POS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      pos_q  <= LAST_POS;
      ws_q   <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) bclk_q <= ~bclk_q;
      if (tick_o.fall) begin
        pos_q <= pos_nxt;
        ws_q  <= ws_nxt;
      end
    end
  end

  assign bclk_o = bclk_q;
  assign ws_o   = ws_q;
  assign pos_o  = pos_q;

  assert_ws_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_q) |-> $fell(bclk_q));
endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
  import i2s_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int POS_W    = $clog2(2 * SLOT_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  i2s_tick_t           tick_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                sdin_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int IDX_W = POS_W - 1;
  localparam logic [IDX_W:0] SAMPLE_LIM = (IDX_W + 1)'(SAMPLE_W);

  logic [SAMPLE_W-1:0] l_sr, r_sr;
  logic                started_q, in_sample, slot;
  logic [IDX_W-1:0]    idx;

  assign slot      = pos_i[POS_W-1];
  assign idx       = pos_i[IDX_W-1:0];
  assign in_sample = ({1'b0, idx} < SAMPLE_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_sr      <= '0;
      r_sr      <= '0;
      started_q <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      if (tick_i.rise && in_sample) begin
        if (slot) r_sr <= {r_sr[SAMPLE_W-2:0], sdin_i};
        else      l_sr <= {l_sr[SAMPLE_W-2:0], sdin_i};
      end
      if (tick_i.frame_start) started_q <= 1'b1;
      valid_o <= tick_i.frame_end && started_q;
      if (tick_i.frame_end && started_q) begin
        left_o  <= l_sr;
        right_o <= r_sr;
      end
    end
  end

  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int POS_W    = $clog2(2 * SLOT_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  i2s_tick_t           tick_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                load_i,
  output logic                sdout_o
);
  localparam int IDX_W = POS_W - 1;
  localparam logic [IDX_W:0] SAMPLE_LIM = (IDX_W + 1)'(SAMPLE_W);

  logic [SAMPLE_W-1:0] pend_l, pend_r, act_l, act_r;
  logic [SAMPLE_W-1:0] src_l, src_r, word, shifted;
  logic [POS_W-1:0]    npos;
  logic [IDX_W-1:0]    nidx;
  logic                nbit, sdout_q;

  assign npos = pos_i + 1'b1;
  assign nidx = npos[IDX_W-1:0];
  // at the frame edge the holding pair is what goes out
  assign src_l = tick_i.frame_start ? pend_l : act_l;
  assign src_r = tick_i.frame_start ? pend_r : act_r;
  assign word  = npos[POS_W-1] ? src_r : src_l;
  assign shifted = word << nidx;
  assign nbit  = ({1'b0, nidx} < SAMPLE_LIM) && shifted[SAMPLE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l  <= '0;
      pend_r  <= '0;
      act_l   <= '0;
      act_r   <= '0;
      sdout_q <= 1'b0;
    end else begin
      if (load_i) begin
        pend_l <= left_i;
        pend_r <= right_i;
      end
      if (tick_i.frame_start) begin
        act_l <= pend_l;
        act_r <= pend_r;
      end
      if (tick_i.fall) sdout_q <= nbit;
    end
  end

  assign sdout_o = sdout_q;
endmodule

// File: rtl/i2s_master_if.sv
module i2s_master_if
  import i2s_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_W    = 32,  // power of two, >= SAMPLE_W
  parameter int BCLK_HALF = 2    // fabric cycles per bclk half period, >= 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                bclk_o,
  output logic                ws_o,
  input  logic                sdin_i,
  output logic                sdout_o,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic                rx_valid_o,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  input  logic                tx_load_i
);
  localparam int POS_W = $clog2(2 * SLOT_W);

  i2s_tick_t        tick;
  logic [POS_W-1:0] pos;

  i2s_timing_gen #(.SLOT_W(SLOT_W), .BCLK_HALF(BCLK_HALF), .POS_W(POS_W)) i_timing (
    .clk_i, .rst_ni, .bclk_o, .ws_o, .tick_o(tick), .pos_o(pos)
  );

  i2s_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .POS_W(POS_W)) i_rx (
    .clk_i, .rst_ni, .tick_i(tick), .pos_i(pos), .sdin_i,
    .left_o(rx_left_o), .right_o(rx_right_o), .valid_o(rx_valid_o)
  );

  i2s_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .POS_W(POS_W)) i_tx (
    .clk_i, .rst_ni, .tick_i(tick), .pos_i(pos),
    .left_i(tx_left_i), .right_i(tx_right_i), .load_i(tx_load_i), .sdout_o
  );

  assert_sdout_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdout_o) |-> $fell(bclk_o));

  assert_valid_at_frame_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (!ws_o && bclk_o));
endmodule

// File: tb/test_i2s_master_if.sv
module test_i2s_master_if;
  localparam int HALF  = 2;
  localparam int MAXF  = 64;
  localparam int MAXLD = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sdin = 1'b0, tx_load = 1'b0;
  logic [23:0] tx_l = '0, tx_r = '0;
  logic bclk, ws, sdout, rx_valid;
  logic [23:0] rx_l_o, rx_r_o;

  always #2.5 clk = ~clk;

  i2s_master_if #(.SAMPLE_W(24), .SLOT_W(32), .BCLK_HALF(HALF)) i_i2s_master_if (
    .clk_i(clk), .rst_ni(rst_n), .bclk_o(bclk), .ws_o(ws), .sdin_i(sdin), .sdout_o(sdout),
    .rx_left_o(rx_l_o), .rx_right_o(rx_r_o), .rx_valid_o(rx_valid),
    .tx_left_i(tx_l), .tx_right_i(tx_r), .tx_load_i(tx_load)
  );

  int errors = 0, checks = 0, cyc = 0, wr_cnt = 0;
  bit done = 0;
  logic [23:0] src_l [MAXF], src_r [MAXF];
  logic [23:0] got_l [MAXF], got_r [MAXF];
  int n_got = 0, n_rx = 0;
  logic [23:0] ld_l [MAXLD], ld_r [MAXLD];
  int ld_frame [MAXLD];
  bit ld_co [MAXLD];
  int n_ld = 0;

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) cyc++;
  always @(posedge ws) wr_cnt++;

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  // ADC model: new bit after each bclk fall, MSB one bit after the ws edge
  initial begin : adc_drv
    int idx = -1, chan = 0, f = 0;
    bit pend = 0;
    logic ws_last = 1'b0;
    forever begin
      @(negedge bclk);
      idx++;
      if (pend) begin
        idx = 0; chan = ws; pend = 0;
        if (chan == 0) f++;
      end
      if (ws != ws_last) pend = 1;
      ws_last = ws;
      if (idx < 24) sdin = (chan == 0) ? src_l[f % MAXF][23-idx] : src_r[f % MAXF][23-idx];
      else          sdin = 1'($urandom);  // don't-care tail bits, R4
    end
  end

  // DAC model: decode slots on bclk rise
  initial begin : dac_mon
    int midx = 0;
    bit on = 0;
    logic mws = 1'b1;
    logic [31:0] w = '0;
    logic [23:0] cur_l = '0;
    forever begin
      @(posedge bclk);
      if (midx < 32) w[31-midx] = sdout;
      midx++;
      if (ws != mws) begin
        if (on) begin
          check(midx == 32, "R2 slot length", 48'(midx), 48'd32);
          check(w[7:0] == 8'h0, "R3 tail bits zero", 48'(w[7:0]), 48'd0);
          if (mws == 1'b0) cur_l = w[31:8];
          else if (n_got < MAXF) begin
            got_l[n_got] = cur_l; got_r[n_got] = w[31:8]; n_got++;
          end
        end
        on = 1; midx = 0; w = '0; mws = ws;
      end
    end
  end

  // captured-pair monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid) begin
        check({rx_l_o, rx_r_o} == {src_l[n_rx % MAXF], src_r[n_rx % MAXF]},
              "R4 captured pair", {rx_l_o, rx_r_o}, {src_l[n_rx % MAXF], src_r[n_rx % MAXF]});
        check(!ws && bclk, "R5 valid position", {46'd0, ws, bclk}, 48'd1);
        n_rx++;
      end
    end
  end

  task automatic do_load(input logic [23:0] l, input logic [23:0] r, input int fr, input bit co);
    @(negedge clk);
    tx_l = l; tx_r = r; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    ld_l[n_ld] = l; ld_r[n_ld] = r; ld_frame[n_ld] = fr; ld_co[n_ld] = co; n_ld++;
  endtask

  task automatic mid_load(input logic [23:0] l, input logic [23:0] r);
    repeat ($urandom_range(0, 90)) @(negedge clk);
    do_load(l, r, wr_cnt - 1, 0);
  endtask

  initial begin
    int t0;
    void'($urandom(32'h5eed_1234));
    src_l[0] = 24'h800000; src_r[0] = 24'h7fffff;
    src_l[1] = 24'hffffff; src_r[1] = 24'h000000;
    src_l[2] = 24'haaaaaa; src_r[2] = 24'h555555;
    src_l[3] = 24'h000001; src_r[3] = 24'h800001;
    for (int i = 4; i < MAXF; i++) begin
      src_l[i] = 24'($urandom); src_r[i] = 24'($urandom);
    end

    repeat (5) @(negedge clk);
    check({bclk, ws, sdout, rx_valid} == 4'b0, "R9 reset outputs", 48'({bclk, ws, sdout, rx_valid}), 48'd0);
    check({rx_l_o, rx_r_o} == 48'd0, "R9 reset pair", {rx_l_o, rx_r_o}, 48'd0);
    rst_n = 1'b1;

    // R1: bclk high time and frame period
    @(posedge bclk); t0 = cyc;
    @(negedge bclk);
    check(cyc - t0 == HALF, "R1 bclk high", 48'(cyc - t0), 48'(HALF));
    @(posedge ws); t0 = cyc;
    @(posedge ws);
    check(cyc - t0 == 128 * HALF, "R1 frame period", 48'(cyc - t0), 48'(128 * HALF));

    // R6/R7: load once, then idle frames repeat it
    @(posedge ws); mid_load(24'h123456, 24'habcdef);
    repeat (3) @(posedge ws);
    // R6: two loads in one frame, the last wins
    mid_load(24'h111111, 24'h222222);
    do_load(24'h333333, 24'h444444, wr_cnt - 1, 0);
    @(posedge ws);
    // R8: load in the frame-start cycle
    @(negedge ws);
    repeat (2 * HALF - 1) @(posedge clk);
    do_load(24'hc0ffee, 24'h0badf0, wr_cnt, 1);
    repeat (2) @(posedge ws);
    @(negedge ws);
    repeat (2 * HALF - 1) @(posedge clk);
    do_load(24'hffffff, 24'h800000, wr_cnt, 1);
    // random mix
    for (int k = 0; k < 18; k++) begin
      @(posedge ws);
      case ($urandom_range(0, 3))
        0: ;
        1, 2: mid_load(24'($urandom), 24'($urandom));
        default: begin
          mid_load(24'($urandom), 24'($urandom));
          do_load(24'($urandom), 24'($urandom), wr_cnt - 1, 0);
        end
      endcase
    end
    repeat (4) @(posedge ws);
    @(negedge clk);

    begin
      int p = 0;
      logic [23:0] cl = '0, cr = '0;
      int last_fr = -1;
      bit last_co = 0;
      string tag;
      for (int f = 0; f < n_got; f++) begin
        bit prev_loaded = 0;
        while (p < n_ld && ld_frame[p] < f) begin
          cl = ld_l[p]; cr = ld_r[p]; last_fr = ld_frame[p]; last_co = ld_co[p];
          p++;
        end
        prev_loaded = (last_fr == f - 1);
        if (f == 0) tag = "R9 first frame zero";
        else if (prev_loaded && last_co) tag = "R8 frame-start load";
        else if (prev_loaded) tag = "R6 load sent next frame";
        else tag = "R7 repeat pair";
        check({got_l[f], got_r[f]} == {cl, cr}, tag, {got_l[f], got_r[f]}, {cl, cr});
      end
    end
    check(n_got >= 30, "R6 frames decoded", 48'(n_got), 48'd30);
    check(n_rx >= n_got - 1 && n_rx <= n_got + 1, "R5 one valid per frame", 48'(n_rx), 48'(n_got));
    finish_run();
  end
endmodule